// File: doc/BRIEF.md
# Framed Transmit Word Buffer with Ramp Sequencing

The block sits between a host that writes transmit words and a modulator that takes one word per symbol strobe. Each word carries a data field, a format bit that tells the modulator how to read the data, and a ramp bit. The words wait in a small first-in first-out store until the modulator asks for them. The ramp bit drives a four-state frame sequencer. The states are idle, ramp-up, active and ramp-down. The length of each ramp phase is counted in symbol strobes.

Software can poll the fill level and the full and empty flags before it writes. As an alternative, it can turn on a hardware handshake. The handshake pulls a serial-clock enable low while the store is full, which stalls the writer. The handshake is only armed while a frame is open, so it cannot lock the port between frames. Two sticky flags record errors: a strobe that finds the store empty while a frame is running, and a write that is lost because the store is full.

Top module: `txframe_fifo`

## Requirements
- R1: After reset:
  - the store is empty, with fifo_level 0, fifo_empty 1 and fifo_full 0;
  - frame_state is 0;
  - both sticky flags are 0;
  - tx_data and tx_fmt are 0;
  - sclk_en is 1.
- R2: The store holds up to DEPTH words and hands them out in write order.
  - fifo_level gives the count of words held.
  - fifo_full is 1 exactly when the count equals DEPTH.
  - fifo_empty is 1 exactly when the count is 0.
- R3: A frame is open while frame_state is not 0, or while the last accepted word had its ramp bit set. A write with wr_ramp clear is discarded when no frame is open.
- R4: A strobe on sym_strobe with a word present removes the head word. tx_data and tx_fmt take the head word's data and format at that same edge, with one exception: in idle, a head word with its ramp bit clear is removed and discarded, and the outputs do not change.
- R5: The frame_state codes are 0 idle, 1 ramp-up, 2 active and 3 ramp-down.
  - In idle, a strobe that removes a word with its ramp bit set moves the block to ramp-up.
  - Ramp-up spans RAMP_LEN strobes, counting the starting one. The block then moves to active.
  - Without a strobe, idle is held.
- R6: In ramp-up or active, a strobe that removes a word with its ramp bit clear starts ramp-down. Ramp-down spans RAMP_LEN strobes, counting that one, and then the block returns to idle. Words removed during ramp-down are output whatever their ramp bit.
- R7: A strobe while frame_state is not 0 and the store is empty sets the sticky underflow flag. The outputs hold their last word, and the ramp strobe count still advances.
- R8: A write while the store is full is dropped. It sets the sticky overflow flag unless the handshake is armed.
- R9: The handshake is armed when hs_enable is 1 and a frame is open. sclk_en is 0 exactly when the handshake is armed and the store is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Data field of the written word |
| wr_fmt | input | 1 | Format bit of the written word |
| wr_ramp | input | 1 | Ramp bit of the written word |
| hs_enable | input | 1 | Turns on the clock-stall handshake |
| sym_strobe | input | 1 | Modulator request for the next word |
| tx_data | output | DATA_W | Data of the last word handed out |
| tx_fmt | output | 1 | Format of the last word handed out |
| frame_state | output | 2 | Frame sequencer state code |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored words |
| fifo_full | output | 1 | Store is full |
| fifo_empty | output | 1 | Store is empty |
| underflow | output | 1 | Sticky: strobe found the store empty during a frame |
| overflow | output | 1 | Sticky: write lost to a full store while unarmed |
| sclk_en | output | 1 | Serial clock enable, low to stall the writer |

## Verification
The bench builds the block with DATA_W 8, the default DEPTH of 4 and RAMP_LEN set to 3. An odd ramp length that differs from the depth separates a counter off-by-one from a FIFO-depth effect. A depth of 4 lets a handful of writes reach full, so the overflow, handshake stall and write-while-full corners come up both in directed frames and in a long random run. Short ramps make many complete frames fit in the random phase. Each complete frame includes a ramp-up exit and a ramp-down exit, and leftover words are discarded in idle.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [1:0] {
    TXF_IDLE = 2'd0,
    TXF_RUP  = 2'd1,
    TXF_ACT  = 2'd2,
    TXF_RDN  = 2'd3
  } txf_state_e;

  // Circular pointer step for any depth.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // The ramp phase ends on the strobe that sees one step left.
  function automatic logic last_step(int unsigned left);
    return left == 1;
  endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_word,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(txf_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(txf_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

endmodule

// File: rtl/txf_frame.sv
module txf_frame
  import txf_pkg::*;
#(
  parameter int RAMP_LEN = 4,
  localparam int CNT_W = $clog2(RAMP_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       empty,
  input  logic       head_ramp,
  output txf_state_e state,
  output logic       pop,
  output logic       load,
  output logic       starve
);

  txf_state_e       st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             ramp_end;

  assign pop      = strobe && !empty;
  assign load     = pop && (state != TXF_IDLE || head_ramp);
  assign starve   = strobe && empty && (state != TXF_IDLE);
  assign ramp_end = last_step(32'(cnt));

  always_comb begin
    st_n  = state;
    cnt_n = cnt;
    if (strobe) begin
      unique case (state)
        TXF_IDLE: if (pop && head_ramp) begin
          st_n  = TXF_RUP;
          cnt_n = CNT_W'(RAMP_LEN - 1);
        end
        TXF_RUP: if (pop && !head_ramp) begin
          st_n  = TXF_RDN;
          cnt_n = CNT_W'(RAMP_LEN - 1);
        end else if (ramp_end) begin
          st_n  = TXF_ACT;
        end else begin
          cnt_n = cnt - 1'b1;
        end
        TXF_ACT: if (pop && !head_ramp) begin
          st_n  = TXF_RDN;
          cnt_n = CNT_W'(RAMP_LEN - 1);
        end
        TXF_RDN: if (ramp_end) st_n = TXF_IDLE;
                 else          cnt_n = cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TXF_IDLE;
      cnt   <= '0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/txf_sticky.sv
module txf_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/txframe_fifo.sv
module txframe_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int RAMP_LEN = 4,
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int WORD_W  = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_fmt,
  input  logic              wr_ramp,
  input  logic              hs_enable,
  input  logic              sym_strobe,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_fmt,
  output logic [1:0]        frame_state,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              underflow,
  output logic              overflow,
  output logic              sclk_en
);

  // Named internal events, visible to the checker.
  logic              frame_open, hs_armed;
  logic              wr_accept, wr_drop_full, wr_drop_closed, ovf_evt;
  logic              pop_evt, load_evt, starve_evt;
  logic              tail_ramp;
  logic [WORD_W-1:0] head;
  txf_state_e        state;

  assign frame_open     = (state != TXF_IDLE) || tail_ramp;
  assign hs_armed       = hs_enable && frame_open;
  assign wr_drop_full   = wr_en && fifo_full;
  assign wr_drop_closed = wr_en && !fifo_full && !wr_ramp && !frame_open;
  assign wr_accept      = wr_en && !fifo_full && !wr_drop_closed;
  assign ovf_evt        = wr_drop_full && !hs_armed;
  assign sclk_en        = !(hs_armed && fifo_full);
  assign frame_state    = state;

  txf_store #(.W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_accept),
    .push_word ({wr_ramp, wr_fmt, wr_data}),
    .pop       (pop_evt),
    .head      (head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  txf_frame #(.RAMP_LEN(RAMP_LEN)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (sym_strobe),
    .empty     (fifo_empty),
    .head_ramp (head[WORD_W-1]),
    .state     (state),
    .pop       (pop_evt),
    .load      (load_evt),
    .starve    (starve_evt)
  );

  txf_sticky #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({ovf_evt, starve_evt}),
    .flag  ({overflow, underflow})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_ramp <= 1'b0;
      tx_data   <= '0;
      tx_fmt    <= 1'b0;
    end else begin
      if (wr_accept) tail_ramp <= wr_ramp;
      if (load_evt) begin
        tx_data <= head[DATA_W-1:0];
        tx_fmt  <= head[DATA_W];
      end
    end
  end

endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_strobe,
  input logic              wr_en,
  input logic              hs_enable,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [1:0]        frame_state,
  input logic              underflow,
  input logic              overflow,
  input logic              sclk_en,
  input logic [DATA_W-1:0] tx_data,
  input logic              pop_evt
);

  // R2: the count never passes the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R2: a full store with no removal keeps its count
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop_evt) |=> (fifo_level == $past(fifo_level)));

  // R2: with no write the count cannot grow
  a_r2_no_write_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (fifo_level <= $past(fifo_level)));

  // R5: idle is held without a strobe
  a_r5_idle_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_state == 2'd0 && !sym_strobe) |=> (frame_state == 2'd0));

  // R6: ramp-down only leaves for idle
  a_r6_rdn_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_state == 2'd3) |=> (frame_state == 2'd3 || frame_state == 2'd0));

  // R7: a starved strobe keeps the last word
  a_r7_hold_on_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_strobe && fifo_empty && frame_state != 2'd0) |=> ($stable(tx_data) && underflow));

  // R7: underflow is sticky
  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R8: overflow is sticky
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: a stall only happens with the handshake on and a full store
  a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |-> (hs_enable && fifo_full));

endmodule

bind txframe_fifo txf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_strobe  (sym_strobe),
  .wr_en       (wr_en),
  .hs_enable   (hs_enable),
  .fifo_level  (fifo_level),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .frame_state (frame_state),
  .underflow   (underflow),
  .overflow    (overflow),
  .sclk_en     (sclk_en),
  .tx_data     (tx_data),
  .pop_evt     (pop_evt)
);

// File: tb/txframe_fifo_test.sv
module txframe_fifo_test;

  localparam int DW = 8;
  localparam int DP = 4;
  localparam int RL = 3;
  localparam int LW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_fmt = 1'b0, wr_ramp = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          hs_enable = 1'b0, sym_strobe = 1'b0;
  logic [DW-1:0] tx_data;
  logic          tx_fmt, fifo_full, fifo_empty, underflow, overflow, sclk_en;
  logic [1:0]    frame_state;
  logic [LW-1:0] fifo_level;

  always #4 clk = ~clk;

  txframe_fifo #(.DATA_W(DW), .DEPTH(DP), .RAMP_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_fmt(wr_fmt),
    .wr_ramp(wr_ramp), .hs_enable(hs_enable), .sym_strobe(sym_strobe),
    .tx_data(tx_data), .tx_fmt(tx_fmt), .frame_state(frame_state),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .underflow(underflow), .overflow(overflow), .sclk_en(sclk_en)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  int mq[$];
  int m_state, m_cnt, m_data, m_fmt;
  bit m_tail, m_unf, m_ovf;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq.delete();
    m_state = 0; m_cnt = 0; m_data = 0; m_fmt = 0;
    m_tail = 0; m_unf = 0; m_ovf = 0;
  endtask

  task automatic model_step();
    int sz = mq.size();
    bit open = (m_state != 0) || m_tail;
    bit full = (sz == DP);
    bit armed = hs_enable && open;
    bit have = sym_strobe && (sz > 0);
    int hd = have ? mq[0] : 0;
    bit hr = hd[DW+1];
    if (wr_en) begin
      if (full) begin
        if (!armed) m_ovf = 1;
      end else if (wr_ramp || open) begin
        mq.push_back({22'd0, wr_ramp, wr_fmt, wr_data});
        m_tail = wr_ramp;
      end
    end
    if (sym_strobe) begin
      if (have) void'(mq.pop_front());
      if (m_state != 0 && !have) m_unf = 1;
      if (have && (m_state != 0 || hr)) begin
        m_data = hd & 255;
        m_fmt  = hd[DW];
      end
      case (m_state)
        0: if (have && hr) begin m_state = 1; m_cnt = RL - 1; end
        1: if (have && !hr) begin m_state = 3; m_cnt = RL - 1; end
           else if (m_cnt == 1) m_state = 2;
           else m_cnt--;
        2: if (have && !hr) begin m_state = 3; m_cnt = RL - 1; end
        default: if (m_cnt == 1) m_state = 0; else m_cnt--;
      endcase
    end
  endtask

  task automatic compare_all();
    bit open = (m_state != 0) || m_tail;
    chk("R2", "level", int'(fifo_level), mq.size());
    chk("R2", "full", int'(fifo_full), int'(mq.size() == DP));
    chk("R2", "empty", int'(fifo_empty), int'(mq.size() == 0));
    chk("R4", "tx_data", int'(tx_data), m_data);
    chk("R4", "tx_fmt", int'(tx_fmt), m_fmt);
    chk("R5", "state", int'(frame_state), m_state);
    chk("R7", "underflow", int'(underflow), int'(m_unf));
    chk("R8", "overflow", int'(overflow), int'(m_ovf));
    chk("R9", "sclk_en", int'(sclk_en), int'(!(hs_enable && open && mq.size() == DP)));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; sym_strobe = 0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1", "reset level", int'(fifo_level), 0);
    chk("R1", "reset empty", int'(fifo_empty), 1);
    chk("R1", "reset state", int'(frame_state), 0);
    chk("R1", "reset flags", int'({underflow, overflow}), 0);
    chk("R1", "reset tx", int'({tx_fmt, tx_data}), 0);
    chk("R1", "reset sclk_en", int'(sclk_en), 1);
    rst_n = 1'b1;
  endtask

  task automatic put(input bit r, input bit f, input int d);
    wr_en = 1; wr_ramp = r; wr_fmt = f; wr_data = DW'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic strobe();
    sym_strobe = 1;
    cyc();
    sym_strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3: closed-frame writes with ramp clear are discarded
    put(0, 0, 8'h01); put(0, 1, 8'h02);
    chk("R3", "idle drop level", int'(fifo_level), 0);

    // R8: fill and overflow with the handshake off
    put(1, 0, 8'h11); put(1, 1, 8'h22); put(1, 0, 8'h33); put(1, 1, 8'h44);
    chk("R2", "full after depth", int'(fifo_full), 1);
    put(1, 0, 8'h55);
    chk("R8", "overflow set", int'(overflow), 1);
    // R5: start and ramp-up length
    strobe();
    chk("R5", "ramp-up entered", int'(frame_state), 1);
    chk("R4", "first word out", int'(tx_data), 8'h11);
    strobe();
    chk("R5", "still ramp-up", int'(frame_state), 1);
    strobe();
    chk("R5", "active after RL", int'(frame_state), 2);
    strobe();
    chk("R4", "fourth word", int'(tx_data), 8'h44);
    // R6: ramp-down
    put(0, 0, 8'h66); put(0, 1, 8'h77); put(0, 0, 8'h78); put(0, 0, 8'h9A);
    strobe();
    chk("R6", "ramp-down entered", int'(frame_state), 3);
    strobe();
    chk("R6", "still ramp-down", int'(frame_state), 3);
    strobe();
    chk("R6", "idle after ramp-down", int'(frame_state), 0);
    chk("R6", "last ramp-down word", int'(tx_data), 8'h78);
    // R4: leftover ramp-clear word is discarded in idle
    strobe();
    chk("R4", "idle discard keeps tx", int'(tx_data), 8'h78);
    chk("R4", "idle discard pops", int'(fifo_level), 0);
    put(0, 0, 8'hAB);
    chk("R3", "drop after frame", int'(fifo_level), 0);

    // R7: starved strobe during ramp-up
    do_reset();
    put(1, 1, 8'hC3);
    strobe();
    strobe();
    chk("R7", "underflow set", int'(underflow), 1);
    chk("R7", "tx held", int'(tx_data), 8'hC3);
    strobe();
    chk("R7", "ramp count advanced", int'(frame_state), 2);

    // R9: handshake stall and armed drop
    do_reset();
    hs_enable = 1;
    @(negedge clk);
    put(1, 0, 8'h01); put(1, 0, 8'h02); put(1, 0, 8'h03); put(1, 0, 8'h04);
    chk("R9", "stall when full", int'(sclk_en), 0);
    put(1, 0, 8'h05);
    chk("R8", "armed drop no overflow", int'(overflow), 0);
    hs_enable = 0;
    #1;
    chk("R9", "no stall when disabled", int'(sclk_en), 1);
    put(1, 0, 8'h06);
    chk("R8", "unarmed drop overflow", int'(overflow), 1);

    // Random phase against the model
    do_reset();
    begin
      bit rb = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(11) == 0) rb = ~rb;
        if ($urandom_range(49) == 0) hs_enable = ~hs_enable;
        wr_en      = ($urandom_range(1) == 1);
        wr_ramp    = rb;
        wr_fmt     = 1'($urandom_range(1));
        wr_data    = DW'($urandom);
        sym_strobe = ($urandom_range(9) < 4);
        cyc();
      end
    end
    wr_en = 0; sym_strobe = 0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule